// File: doc/BRIEF.md
# Store-Sequence Load Verification Filter

This block decides, just before a load commits, whether the value that load obtained can still be trusted. It keeps a small direct-mapped table of store sequence numbers (SSNs). Each table slot covers every address word whose folded index lands on it. Each time a store finishes writing the data cache, its SSN is written into the slot for its address, and the SSN of the last completed store is kept as the completion mark. A load that is ready to commit presents its address and a bound SSN. For a load that read the cache, the bound is the newest store it is already known to be ordered after. For a load that forwarded from an in-flight store, the bound is that store's SSN.

The filter returns one of three verdicts one cycle later. SAFE means the load may commit. REPLAY means the load must be re-executed. WAIT means the load forwarded from a store that has not yet reached the cache, so the load is presented again later. Because several addresses share a slot, a verdict may ask for a replay that was not needed. It never passes a load that a completed store has overwritten. This lookup takes the place of an associative search over all in-flight loads.

Top module: `ssn_load_filter`

## Requirements
- R1: A synchronous active-high reset clears every slot to SSN 0 and sets the completion mark to 0. After reset, a load that did not forward gets SAFE for any bound, including bound 0.
- R2: `vr_vld` is high exactly one cycle after a cycle with `ld_vld` high, and low otherwise. `vr_code` is encoded as SAFE=0, REPLAY=1, WAIT=2, and never takes the value 3.
- R3: A store completion (`st_vld`) writes `st_ssn` into the slot selected by `st_addr`. Slots with other indexes keep their value.
- R4: A load that is not waiting gets REPLAY when its slot holds an SSN strictly greater than `ld_bound`.
- R5: A load that is not waiting gets SAFE when its slot holds an SSN less than or equal to `ld_bound`. Equality counts as SAFE.
- R6: The slot index is the XOR of consecutive 6-bit chunks of `st_addr[31:3]`/`ld_addr[31:3]`, with zero padding at the top. Distinct addresses with the same index share a slot, so such a load gets REPLAY even though its own address was not written.
- R7: A load with `ld_fwd`=1 and `ld_bound` greater than the completion mark gets WAIT. The completion mark is the `st_ssn` of the most recent store completion.
- R8: A load with `ld_fwd`=1 whose bound is at or below the completion mark is judged by the slot comparison of R4/R5.
- R9: When a store completion and a load verify occur in the same cycle, the store is applied first, both to the slot and to the completion mark, before the load is judged.
- R10: A load whose exact address received a completed store with SSN above its bound never gets SAFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_vld | input | 1 | A store has completed to the cache this cycle |
| st_addr | input | 32 | Byte address of the completed store |
| st_ssn | input | 16 | Sequence number of the completed store |
| ld_vld | input | 1 | A load requests verification this cycle |
| ld_addr | input | 32 | Byte address of the load |
| ld_bound | input | 16 | SSN up to which the load's value is known safe (source store SSN if forwarded) |
| ld_fwd | input | 1 | The load took its value from an in-flight store |
| vr_vld | output | 1 | Verdict valid (one cycle after `ld_vld`) |
| vr_code | output | 2 | Verdict: 0 SAFE, 1 REPLAY, 2 WAIT |

## Verification
The hardest case to reach is the one where two things land in the same cycle: a store completing to the very slot a load is checking. The harder variant is when that store also moves the completion mark across a forwarded load's bound, so the WAIT-or-judge choice hangs on the same-cycle update. Directed vectors place a store and a load on one slot in a single cycle, both with and without forwarding. They also use a second address chosen to fold onto the same index, to provoke an aliasing replay. A long random phase then draws addresses from a small pool, so that slots collide often. Its stores carry rising SSNs, and its bounds straddle both slot contents and the completion mark. Each verdict is compared with a slot-level model and with an exact per-address model that counts false replays.

// File: rtl/ssnf_pkg.sv
package ssnf_pkg;
  typedef enum logic [1:0] {
    VRD_SAFE   = 2'd0,
    VRD_REPLAY = 2'd1,
    VRD_WAIT   = 2'd2
  } verdict_e;
endpackage

// File: rtl/ssnf_hash.sv
// Folds the word address into a table index by XOR of IDX_W-bit chunks.
module ssnf_hash #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 3,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_W = ADDR_W - OFS_W;
  localparam int NCH    = (WORD_W + IDX_W - 1) / IDX_W;

  logic [NCH*IDX_W-1:0] padded;
  logic [IDX_W-1:0]     fold [NCH+1];
  logic                 unused_ofs;

  assign unused_ofs = ^addr[OFS_W-1:0];

  always_comb begin
    padded = '0;
    padded[WORD_W-1:0] = addr[ADDR_W-1:OFS_W];
  end

  assign fold[0] = '0;
  for (genvar k = 0; k < NCH; k++) begin : g_fold
    assign fold[k+1] = fold[k] ^ padded[k*IDX_W +: IDX_W];
  end

  assign idx = fold[NCH];
endmodule

// File: rtl/ssnf_table.sv
// Direct-mapped SSN storage. Data array carries no reset (RAM-friendly);
// a per-slot valid vector provides the all-zero state after reset.
module ssnf_table #(
  parameter int IDX_W = 6,
  parameter int SSN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SSN_W-1:0] wr_ssn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SSN_W-1:0] rd_ssn
);
  localparam int DEPTH = 1 << IDX_W;

  logic [SSN_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] slot_ok;
  logic [SSN_W-1:0] raw_ssn;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ssn;
  end

  always_ff @(posedge clk) begin
    if (rst)        slot_ok <= '0;
    else if (wr_en) slot_ok[wr_idx] <= 1'b1;
  end

  assign raw_ssn = slot_ok[rd_idx] ? mem[rd_idx] : '0;

  // same-cycle store to the same slot is seen first
  always_comb begin
    if (wr_en && (wr_idx == rd_idx)) rd_ssn = wr_ssn;
    else                             rd_ssn = raw_ssn;
  end

  // R3
  slot_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rst) |=> slot_ok[$past(wr_idx)]);
endmodule

// File: rtl/ssnf_judge.sv
// Forms the registered verdict from slot SSN, completion mark and load request.
module ssnf_judge
  import ssnf_pkg::*;
#(
  parameter int SSN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_vld,
  input  logic             ld_fwd,
  input  logic [SSN_W-1:0] ld_bound,
  input  logic [SSN_W-1:0] ent_ssn,
  input  logic [SSN_W-1:0] done_ssn,
  output logic             vr_vld,
  output verdict_e         vr_code
);
  verdict_e nxt_code;

  always_comb begin
    if (ld_fwd && (ld_bound > done_ssn)) nxt_code = VRD_WAIT;
    else if (ent_ssn > ld_bound)         nxt_code = VRD_REPLAY;
    else                                 nxt_code = VRD_SAFE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vr_vld  <= 1'b0;
      vr_code <= VRD_SAFE;
    end else begin
      vr_vld <= ld_vld;
      if (ld_vld) vr_code <= nxt_code;
    end
  end

  // R7
  wait_needs_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (vr_vld && vr_code == VRD_WAIT) |-> $past(ld_fwd));

  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    vr_code != 2'd3);
endmodule

// File: rtl/ssn_load_filter.sv
module ssn_load_filter
  import ssnf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 3,
  parameter int IDX_W  = 6,
  parameter int SSN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SSN_W-1:0]  st_ssn,
  input  logic              ld_vld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SSN_W-1:0]  ld_bound,
  input  logic              ld_fwd,
  output logic              vr_vld,
  output logic [1:0]        vr_code
);
  logic [IDX_W-1:0] st_idx, ld_idx;
  logic [SSN_W-1:0] ent_ssn, done_q, done_eff;
  verdict_e         code_e;

  ssnf_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_hash_st (
    .addr(st_addr), .idx(st_idx));
  ssnf_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_hash_ld (
    .addr(ld_addr), .idx(ld_idx));

  ssnf_table #(.IDX_W(IDX_W), .SSN_W(SSN_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(st_vld), .wr_idx(st_idx), .wr_ssn(st_ssn),
    .rd_idx(ld_idx), .rd_ssn(ent_ssn));

  // completion mark: SSN of the last store that reached the cache
  always_ff @(posedge clk) begin
    if (rst)         done_q <= '0;
    else if (st_vld) done_q <= st_ssn;
  end

  assign done_eff = st_vld ? st_ssn : done_q;

  ssnf_judge #(.SSN_W(SSN_W)) u_judge (
    .clk(clk), .rst(rst),
    .ld_vld(ld_vld), .ld_fwd(ld_fwd), .ld_bound(ld_bound),
    .ent_ssn(ent_ssn), .done_ssn(done_eff),
    .vr_vld(vr_vld), .vr_code(code_e));

  assign vr_code = code_e;

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !vr_vld);

  // R2
  verdict_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vr_vld == $past(ld_vld)));

  // R9
  same_cycle_store_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_vld && !ld_fwd && st_vld && st_idx == ld_idx && st_ssn > ld_bound)
      |=> (vr_code == 2'd1));
endmodule

// File: tb/ssn_load_filter_tb_top.sv
`timescale 1ns/1ps
module ssn_load_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_vld = 1'b0;
  logic [31:0] st_addr = '0;
  logic [15:0] st_ssn = '0;
  logic        ld_vld = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [15:0] ld_bound = '0;
  logic        ld_fwd = 1'b0;
  logic        vr_vld;
  logic [1:0]  vr_code;

  int n_cmp = 0;
  int n_bad = 0;
  int n_false = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ssn_load_filter dut_i (
    .clk(clk), .rst(rst),
    .st_vld(st_vld), .st_addr(st_addr), .st_ssn(st_ssn),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_bound(ld_bound), .ld_fwd(ld_fwd),
    .vr_vld(vr_vld), .vr_code(vr_code));

  typedef struct packed {
    logic        sv;
    logic [31:0] sa;
    logic [15:0] ss;
    logic        lv;
    logic [31:0] la;
    logic [15:0] lb;
    logic        lf;
    logic        ev;
    logic [1:0]  ec;
  } vec_t;

  // A=0x100 (idx 0x20), B=0x308 (aliases A), C=0x40 (idx 0x08)
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h100, 16'd0,  1'b0, 1'b1, 2'd0}, // R1
    '{1'b1, 32'h100, 16'd5, 1'b0, 32'h0,   16'd0,  1'b0, 1'b0, 2'd0}, // R2
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h100, 16'd4,  1'b0, 1'b1, 2'd1}, // R4
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h100, 16'd5,  1'b0, 1'b1, 2'd0}, // R5
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h308, 16'd4,  1'b0, 1'b1, 2'd1}, // R6
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h40,  16'd0,  1'b0, 1'b1, 2'd0}, // R3
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h40,  16'd7,  1'b1, 1'b1, 2'd2}, // R7
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h40,  16'd5,  1'b1, 1'b1, 2'd0}, // R8
    '{1'b1, 32'h40,  16'd7, 1'b1, 32'h40,  16'd7,  1'b1, 1'b1, 2'd0}, // R9
    '{1'b1, 32'h100, 16'd9, 1'b1, 32'h100, 16'd8,  1'b0, 1'b1, 2'd1}, // R9
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h100, 16'd8,  1'b1, 1'b1, 2'd1}, // R8
    '{1'b0, 32'h0,   16'd0, 1'b1, 32'h40,  16'd10, 1'b1, 1'b1, 2'd2}  // R7
  };
  string VTAG [NV] = '{"R1","R2","R4","R5","R6","R3","R7","R8","R9","R9","R8","R7"};

  task automatic check(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R6 index rule, written from the requirement
  function automatic logic [5:0] idx_of(input logic [31:0] a);
    logic [35:0] w = {7'd0, a[31:3]};
    logic [5:0]  r = '0;
    for (int k = 0; k < 6; k++) r ^= w[k*6 +: 6];
    return r;
  endfunction

  task automatic go_idle();
    st_vld = 1'b0; ld_vld = 1'b0; ld_fwd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("false replays observed: %0d", n_false);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [15:0] tab [64];
  logic [15:0] exact [logic [31:0]];
  logic [15:0] done_m;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", int'(vr_vld), 0, "vr_vld during reset");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      st_vld = VEC[i].sv; st_addr = VEC[i].sa; st_ssn = VEC[i].ss;
      ld_vld = VEC[i].lv; ld_addr = VEC[i].la; ld_bound = VEC[i].lb; ld_fwd = VEC[i].lf;
      @(posedge clk); #2;
      go_idle();
      check(VTAG[i], int'(vr_vld), int'(VEC[i].ev), $sformatf("vec %0d vr_vld", i));
      if (VEC[i].ev) check(VTAG[i], int'(vr_code), int'(VEC[i].ec), $sformatf("vec %0d vr_code", i));
    end

    // R1: reset mid-run clears slots and completion mark
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check("R1", int'(vr_vld), 0, "vr_vld in reset");
    @(negedge clk); rst = 1'b0;
    ld_vld = 1'b1; ld_addr = 32'h100; ld_bound = 16'd0; ld_fwd = 1'b0;
    @(posedge clk); #2; go_idle();
    check("R1", int'(vr_code), 0, "slot cleared, bound 0");
    @(negedge clk);
    ld_vld = 1'b1; ld_addr = 32'h40; ld_bound = 16'd1; ld_fwd = 1'b1;
    @(posedge clk); #2; go_idle();
    check("R7", int'(vr_code), 2, "completion mark cleared by reset");

    // random phase against slot model and exact-address model (R10)
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 64; k++) tab[k] = '0;
    exact.delete();
    done_m = '0;
    begin
      logic [15:0] ssn_ctr = 16'd0;
      for (int c = 0; c < 4000; c++) begin
        logic [1:0]  exp_c;
        logic [15:0] ent, deff, ex_last;
        logic        exp_v;
        @(negedge clk);
        st_vld = ($urandom_range(0, 2) == 0);
        st_addr = 32'($urandom_range(0, 255)) << 3;
        if (st_vld) ssn_ctr = ssn_ctr + 16'd1;
        st_ssn = ssn_ctr;
        ld_vld = ($urandom_range(0, 3) != 0);
        ld_addr = 32'($urandom_range(0, 255)) << 3;
        ld_fwd = ($urandom_range(0, 3) == 0);
        ld_bound = 16'(int'(ssn_ctr) + 3 - int'($urandom_range(0, 11)));
        if (int'(ssn_ctr) + 3 < 11 && ld_bound > ssn_ctr + 16'd3) ld_bound = 16'd0;
        exp_v = ld_vld;
        deff = st_vld ? st_ssn : done_m;
        ent = (st_vld && idx_of(st_addr) == idx_of(ld_addr)) ? st_ssn : tab[idx_of(ld_addr)];
        if (st_vld && st_addr == ld_addr) ex_last = st_ssn;
        else if (exact.exists(ld_addr)) ex_last = exact[ld_addr];
        else ex_last = '0;
        if (ld_fwd && ld_bound > deff) exp_c = 2'd2;
        else if (ent > ld_bound) exp_c = 2'd1;
        else exp_c = 2'd0;
        if (st_vld) begin
          tab[idx_of(st_addr)] = st_ssn;
          exact[st_addr] = st_ssn;
          done_m = st_ssn;
        end
        @(posedge clk); #2;
        check("R2", int'(vr_vld), int'(exp_v), "random vr_vld");
        if (exp_v) begin
          check("R4", int'(vr_code), int'(exp_c), "random verdict vs slot model");
          if (ex_last > ld_bound) check("R10", int'(vr_code != 2'd0), 1, "missed conflict");
          else if (vr_code == 2'd1) n_false++;
        end
      end
    end
    go_idle();
    finish_run();
  end
endmodule